// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device out of power-up and into a state where normal accesses can begin. After reset is released it enables the memory clock, holds off for a long stabilisation interval, closes every bank with one precharge, runs a programmable number of auto-refresh cycles and then writes the device mode register. It keeps the required spacing between these commands, and once the load-to-active delay has elapsed it raises a completion flag. The memory controller that owns the device afterwards treats that flag as its go signal.

Each interval is a parameter counted in clock cycles, except the stabilisation wait. That wait is given in microseconds together with the clock frequency, so a simulation can shorten it without touching anything else. The burst length and CAS latency parameters are encoded into the mode word when the design is elaborated. The same word always selects sequential bursts, standard operation and single-location write bursts. All pin outputs are registered, so every command reaches the device pins one cycle after the sequencer state that issues it.

Top module: `sdram_boot_seq`

## Requirements
- R1: While rst_n is low the outputs are: clk_en low; cs_n, ras_n, cas_n and we_n all high (deselect); bank and addr zero; init_done low.
- R2: After reset is released clk_en goes high and stays high. Exactly STARTUP_CYC = (CLK_HZ / 1000000) * STARTUP_US cycles pass from the first cycle with clk_en high to the precharge command, and no other command appears in between.
- R3: The precharge-all command is cs_n=0, ras_n=0, cas_n=1, we_n=0 with addr bit 10 set to 1. It is issued exactly once per sequence.
- R4: Exactly REFRESH_COUNT auto-refresh commands follow (cs_n=0, ras_n=0, cas_n=0, we_n=1). The first comes TRP_CYC cycles after the precharge and each later one TRFC_CYC cycles after the previous one.
- R5: The load-mode command (cs_n, ras_n, cas_n and we_n all 0) comes TRFC_CYC cycles after the last refresh, with bank equal to zero.
- R6: During load-mode, addr carries the mode word. Bits 2:0 hold the burst length code (0, 1 or 2 for a burst of 1, 2 or 4). Bit 3 is 0 (sequential). Bits 6:4 hold the CAS latency (2 or 3). Bits 8:7 are 0 (standard operation). Bit 9 is 1 (single-location write bursts). All higher bits are 0.
- R7: init_done rises exactly TMRD_CYC cycles after the load-mode command.
- R8: Any cycle with clk_en high that carries none of the three commands is a NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1). This includes every cycle after init_done rises.
- R9: init_done stays high until the next reset. A reset asserted at any point returns the outputs to the R1 state, and after release the whole sequence restarts from R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller and SDRAM clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| bank | output | BANK_W | Bank select |
| addr | output | ADDR_W | Address bus; carries the all-banks bit and the mode word |
| init_done | output | 1 | High once the start-up sequence is complete |

## Verification
Some rules can be judged on every cycle, and embedded properties check those. They check that the chip stays deselected while the clock is disabled, and that each precharge selects all banks. They check that every command is followed by a NOP, that load-mode targets bank zero and only comes after the full refresh count, and that init_done is sticky and quiet once set. The exact cycle distances between commands, the command order, the refresh count and the mode-word value depend on the whole history. Only the bench scenarios can show these: a scoreboard of expected commands with their spacings is compared against what appears at the pins. The same applies to the restart after a reset in the middle of the refresh phase.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

   // Abstract command chosen by the sequencer each cycle
   typedef enum logic [2:0] {
      CMD_DESEL = 3'd0,
      CMD_NOP   = 3'd1,
      CMD_PRE   = 3'd2,
      CMD_REF   = 3'd3,
      CMD_LMR   = 3'd4
   } boot_cmd_e;

   // Sequencer states
   typedef enum logic [3:0] {
      ST_RESET = 4'd0,
      ST_POWER = 4'd1,
      ST_PRE   = 4'd2,
      ST_TRP   = 4'd3,
      ST_REF   = 4'd4,
      ST_TRFC  = 4'd5,
      ST_LMR   = 4'd6,
      ST_TMRD  = 4'd7,
      ST_DONE  = 4'd8
   } boot_state_e;

   // Control strobes in pin order cs_n, ras_n, cas_n, we_n
   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } strobe_t;

   function automatic strobe_t encode_cmd(input boot_cmd_e c);
      strobe_t s;
      case (c)
         CMD_NOP: s = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
         CMD_PRE: s = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
         CMD_REF: s = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
         CMD_LMR: s = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
         default: s = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
      endcase
      return s;
   endfunction

endpackage

// File: rtl/sdram_boot_timer.sv
// Down counter shared by all waiting intervals of the sequencer
module sdram_boot_timer #(
   parameter int unsigned TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_boot_modeword.sv
// Builds the constant mode-register word from the burst and latency options
module sdram_boot_modeword #(
   parameter int unsigned ADDR_W    = 13,
   parameter int unsigned BURST_LEN = 1,
   parameter int unsigned CAS_LAT   = 2
) (
   output logic [ADDR_W-1:0] word
);
   localparam int unsigned LOW_W = 10;

   logic [2:0] burst_code;
   logic [2:0] cas_code;

   generate
      case (BURST_LEN)
         1: begin : g_bl1
            assign burst_code = 3'd0;
         end
         2: begin : g_bl2
            assign burst_code = 3'd1;
         end
         4: begin : g_bl4
            assign burst_code = 3'd2;
         end
         default: begin : g_bl_bad
            $error("sdram_boot_modeword: BURST_LEN must be 1, 2 or 4");
            assign burst_code = 3'd0;
         end
      endcase

      if (CAS_LAT == 2 || CAS_LAT == 3) begin : g_cas_ok
         assign cas_code = 3'(CAS_LAT);
      end else begin : g_cas_bad
         $error("sdram_boot_modeword: CAS_LAT must be 2 or 3");
         assign cas_code = 3'd2;
      end

      if (ADDR_W < 11) begin : g_aw_bad
         $error("sdram_boot_modeword: ADDR_W must be at least 11");
      end
   endgenerate

   // bit 9 single-location writes, bits 8:7 standard mode, bit 3 sequential
   logic [LOW_W-1:0] low_word;
   assign low_word = {1'b1, 2'b00, cas_code, 1'b0, burst_code};
   assign word     = ADDR_W'(low_word);

endmodule

// File: rtl/sdram_boot_ctrl.sv
// Sequencer state machine: chooses the command for each cycle
module sdram_boot_ctrl
   import sdram_boot_pkg::*;
#(
   parameter int unsigned STARTUP_CYC   = 200,
   parameter int unsigned TRP_CYC       = 3,
   parameter int unsigned TRFC_CYC      = 7,
   parameter int unsigned TMRD_CYC      = 2,
   parameter int unsigned REFRESH_COUNT = 8
) (
   input  logic      clk,
   input  logic      rst_n,
   output boot_cmd_e cmd,
   output logic      clk_on,
   output logic      done
);
   localparam int unsigned MAX_A  = (STARTUP_CYC > TRFC_CYC) ? STARTUP_CYC : TRFC_CYC;
   localparam int unsigned MAX_B  = (TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC;
   localparam int unsigned MAX_D  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int unsigned TW     = $clog2(MAX_D + 1);
   localparam int unsigned RC_W   = $clog2(REFRESH_COUNT + 1);
   localparam logic [TW-1:0] LD_STARTUP = TW'(STARTUP_CYC - 1);
   localparam logic [TW-1:0] LD_TRP     = TW'(TRP_CYC - 2);
   localparam logic [TW-1:0] LD_TRFC    = TW'(TRFC_CYC - 2);
   localparam logic [TW-1:0] LD_TMRD    = (TMRD_CYC >= 2) ? TW'(TMRD_CYC - 2) : '0;
   localparam logic [RC_W-1:0] REF_LAST = RC_W'(REFRESH_COUNT);

   boot_state_e    state_q, state_d;
   logic [RC_W-1:0] ref_cnt_q;
   logic           tmr_load;
   logic [TW-1:0]  tmr_val;
   logic           tmr_expired;

   sdram_boot_timer #(.TW(TW)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (state_q)
         ST_RESET: begin
            state_d  = ST_POWER;
            tmr_load = 1'b1;
            tmr_val  = LD_STARTUP;
         end
         ST_POWER: begin
            if (tmr_expired) state_d = ST_PRE;
         end
         ST_PRE: begin
            state_d  = ST_TRP;
            tmr_load = 1'b1;
            tmr_val  = LD_TRP;
         end
         ST_TRP: begin
            if (tmr_expired) state_d = ST_REF;
         end
         ST_REF: begin
            state_d  = ST_TRFC;
            tmr_load = 1'b1;
            tmr_val  = LD_TRFC;
         end
         ST_TRFC: begin
            if (tmr_expired) begin
               state_d = (ref_cnt_q == REF_LAST) ? ST_LMR : ST_REF;
            end
         end
         ST_LMR: begin
            if (TMRD_CYC >= 2) begin
               state_d  = ST_TMRD;
               tmr_load = 1'b1;
               tmr_val  = LD_TMRD;
            end else begin
               state_d = ST_DONE;
            end
         end
         ST_TMRD: begin
            if (tmr_expired) state_d = ST_DONE;
         end
         ST_DONE: state_d = ST_DONE;
         default: state_d = ST_RESET;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_RESET;
         ref_cnt_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_REF) ref_cnt_q <= ref_cnt_q + 1'b1;
      end
   end

   always_comb begin
      case (state_q)
         ST_RESET: cmd = CMD_DESEL;
         ST_PRE:   cmd = CMD_PRE;
         ST_REF:   cmd = CMD_REF;
         ST_LMR:   cmd = CMD_LMR;
         default:  cmd = CMD_NOP;
      endcase
   end

   assign clk_on = (state_q != ST_RESET);
   assign done   = (state_q == ST_DONE);

   // R4
   ref_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LMR) |-> (ref_cnt_q == REF_LAST))
      else $error("load-mode issued before all refreshes");

   // R4
   ref_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_REF) |-> (ref_cnt_q < REF_LAST))
      else $error("refresh issued beyond the configured count");

endmodule

// File: rtl/sdram_boot_pins.sv
// Registered pin stage: turns the abstract command into SDRAM pin levels
module sdram_boot_pins
   import sdram_boot_pkg::*;
#(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  boot_cmd_e         cmd,
   input  logic              clk_on,
   input  logic              done,
   input  logic [ADDR_W-1:0] mode_word,
   output logic              clk_en,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BANK_W-1:0] bank,
   output logic [ADDR_W-1:0] addr,
   output logic              init_done
);
   localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

   strobe_t           strobe_d;
   logic [ADDR_W-1:0] addr_d;

   assign strobe_d = encode_cmd(cmd);

   always_comb begin
      case (cmd)
         CMD_PRE: addr_d = ALL_BANKS;
         CMD_LMR: addr_d = mode_word;
         default: addr_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_en    <= 1'b0;
         cs_n      <= 1'b1;
         ras_n     <= 1'b1;
         cas_n     <= 1'b1;
         we_n      <= 1'b1;
         bank      <= '0;
         addr      <= '0;
         init_done <= 1'b0;
      end else begin
         clk_en    <= clk_on;
         cs_n      <= strobe_d.cs_n;
         ras_n     <= strobe_d.ras_n;
         cas_n     <= strobe_d.cas_n;
         we_n      <= strobe_d.we_n;
         bank      <= '0;
         addr      <= addr_d;
         init_done <= done;
      end
   end

   logic pin_nop, pin_pre, pin_lmr, pin_any_cmd;
   assign pin_nop     = !cs_n && ras_n && cas_n && we_n;
   assign pin_pre     = !cs_n && !ras_n && cas_n && !we_n;
   assign pin_lmr     = !cs_n && !ras_n && !cas_n && !we_n;
   assign pin_any_cmd = !cs_n && !pin_nop;

   // R2
   desel_without_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |-> cs_n)
      else $error("chip selected while clock enable low");

   // R2
   clk_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en |=> clk_en)
      else $error("clock enable dropped after start");

   // R3
   pre_all_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_pre |-> addr[10])
      else $error("precharge without all-banks bit");

   // R5
   lmr_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_lmr |-> (bank == '0 && !init_done))
      else $error("load-mode with nonzero bank or after done");

   // R8
   cmd_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_any_cmd |=> pin_nop)
      else $error("back-to-back commands");

   // R8
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (pin_nop && clk_en))
      else $error("non-NOP after completion");

   // R9
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done)
      else $error("init_done fell without reset");

endmodule

// File: rtl/sdram_boot_seq.sv
// SDRAM power-up initialization sequencer (top)
module sdram_boot_seq
   import sdram_boot_pkg::*;
#(
   parameter int unsigned CLK_HZ        = 100_000_000,
   parameter int unsigned STARTUP_US    = 100_000,
   parameter int unsigned TRP_CYC       = 3,
   parameter int unsigned TRFC_CYC      = 7,
   parameter int unsigned TMRD_CYC      = 2,
   parameter int unsigned REFRESH_COUNT = 8,
   parameter int unsigned BURST_LEN     = 1,
   parameter int unsigned CAS_LAT       = 2,
   parameter int unsigned ADDR_W        = 13,
   parameter int unsigned BANK_W        = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              clk_en,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BANK_W-1:0] bank,
   output logic [ADDR_W-1:0] addr,
   output logic              init_done
);
   localparam int unsigned CYC_PER_US  = CLK_HZ / 1_000_000;
   localparam int unsigned STARTUP_CYC = CYC_PER_US * STARTUP_US;

   generate
      if (STARTUP_CYC < 1) begin : g_bad_startup
         $error("sdram_boot_seq: start-up wait must be at least one cycle");
      end
      if (TRP_CYC < 2 || TRFC_CYC < 2) begin : g_bad_gap
         $error("sdram_boot_seq: TRP_CYC and TRFC_CYC must be at least 2");
      end
      if (TMRD_CYC < 1) begin : g_bad_tmrd
         $error("sdram_boot_seq: TMRD_CYC must be at least 1");
      end
      if (REFRESH_COUNT < 1) begin : g_bad_ref
         $error("sdram_boot_seq: REFRESH_COUNT must be at least 1");
      end
      if (BANK_W < 1) begin : g_bad_bank
         $error("sdram_boot_seq: BANK_W must be at least 1");
      end
   endgenerate

   boot_cmd_e         cmd;
   logic              clk_on;
   logic              done;
   logic [ADDR_W-1:0] mode_word;

   sdram_boot_ctrl #(
      .STARTUP_CYC   (STARTUP_CYC),
      .TRP_CYC       (TRP_CYC),
      .TRFC_CYC      (TRFC_CYC),
      .TMRD_CYC      (TMRD_CYC),
      .REFRESH_COUNT (REFRESH_COUNT)
   ) ctrl_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd    (cmd),
      .clk_on (clk_on),
      .done   (done)
   );

   sdram_boot_modeword #(
      .ADDR_W    (ADDR_W),
      .BURST_LEN (BURST_LEN),
      .CAS_LAT   (CAS_LAT)
   ) modeword_i (
      .word (mode_word)
   );

   sdram_boot_pins #(
      .ADDR_W (ADDR_W),
      .BANK_W (BANK_W)
   ) pins_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd),
      .clk_on    (clk_on),
      .done      (done),
      .mode_word (mode_word),
      .clk_en    (clk_en),
      .cs_n      (cs_n),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .we_n      (we_n),
      .bank      (bank),
      .addr      (addr),
      .init_done (init_done)
   );

endmodule

// File: tb/sdram_boot_seq_tb_top.sv
module sdram_boot_seq_tb_top;

   localparam int unsigned CLK_HZ     = 200_000_000;
   localparam int unsigned STARTUP_US = 1;
   localparam int unsigned TRP        = 3;
   localparam int unsigned TRFC       = 5;
   localparam int unsigned TMRD       = 2;
   localparam int unsigned NREF       = 3;
   localparam int unsigned BL         = 4;
   localparam int unsigned CL         = 3;
   localparam int unsigned AW         = 13;
   localparam int unsigned BW         = 2;
   localparam int unsigned STARTUP    = (CLK_HZ / 1_000_000) * STARTUP_US;

   localparam int K_CKE = 0, K_PRE = 1, K_REF = 2, K_LMR = 3, K_DONE = 4, K_BAD = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clk_en, cs_n, ras_n, cas_n, we_n, init_done;
   logic [BW-1:0] bank;
   logic [AW-1:0] addr;

   always #2.5 clk = ~clk;

   sdram_boot_seq #(
      .CLK_HZ(CLK_HZ), .STARTUP_US(STARTUP_US), .TRP_CYC(TRP), .TRFC_CYC(TRFC),
      .TMRD_CYC(TMRD), .REFRESH_COUNT(NREF), .BURST_LEN(BL), .CAS_LAT(CL),
      .ADDR_W(AW), .BANK_W(BW)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .bank(bank), .addr(addr), .init_done(init_done)
   );

   typedef struct {
      int    kind;
      int    gap;
      int    addr;
      string req;
   } exp_t;

   exp_t q[$];
   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic int mode_word_exp();
      int bl_code;
      case (BL)
         1: bl_code = 0;
         2: bl_code = 1;
         default: bl_code = 2;
      endcase
      return bl_code | (CL << 4) | (1 << 9);  // R6 field layout
   endfunction

   task automatic push(input int kind, input int gap, input int a, input string req);
      exp_t e;
      e.kind = kind; e.gap = gap; e.addr = a; e.req = req;
      q.push_back(e);
   endtask

   // Driver: the full expected command stream for one start-up
   task automatic push_sequence();
      push(K_CKE, -1, 0, "R2");
      push(K_PRE, STARTUP, 0, "R3");
      push(K_REF, TRP, 0, "R4");
      for (int i = 1; i < NREF; i++) push(K_REF, TRFC, 0, "R4");
      push(K_LMR, TRFC, mode_word_exp(), "R6");
      push(K_DONE, TMRD, 0, "R7");
   endtask

   // Monitor
   int  cyc = 0;
   int  last_ev = 0;
   bit  prev_cke = 1'b0;
   bit  prev_done = 1'b0;
   int  r8_bad = 0;

   task automatic score(input int kind);
      exp_t e;
      if (q.size() == 0) begin
         check(1'b0, "R9", "unexpected event kind", kind, -1);
         return;
      end
      e = q.pop_front();
      check(kind == e.kind, e.req, "event kind", kind, e.kind);
      if (e.gap >= 0) check((cyc - last_ev) == e.gap, e.req, "cycle gap", cyc - last_ev, e.gap);
      if (kind == K_PRE) check(addr[10] == 1'b1, "R3", "all-banks bit", int'(addr[10]), 1);
      if (kind == K_LMR) begin
         check(int'(addr) == e.addr, "R6", "mode word", int'(addr), e.addr);
         check(bank == '0, "R5", "load-mode bank", int'(bank), 0);
      end
      last_ev = cyc;
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         cyc = 0; last_ev = 0; prev_cke = 1'b0; prev_done = 1'b0;
      end else begin
         cyc++;
         if (clk_en && !prev_cke) score(K_CKE);
         if (!clk_en && prev_cke) check(1'b0, "R2", "clock enable dropped", 0, 1);
         if (!cs_n && !(ras_n && cas_n && we_n)) begin
            case ({ras_n, cas_n, we_n})
               3'b010:  score(K_PRE);
               3'b001:  score(K_REF);
               3'b000:  score(K_LMR);
               default: score(K_BAD);
            endcase
         end
         if (clk_en && cs_n) r8_bad++;
         if (init_done && !prev_done) score(K_DONE);
         if (!init_done && prev_done) check(1'b0, "R9", "init_done fell", 0, 1);
         prev_cke = clk_en;
         prev_done = init_done;
      end
   end

   task automatic check_reset_state();
      check(clk_en == 1'b0, "R1", "clk_en in reset", int'(clk_en), 0);
      check({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R1", "strobes in reset",
            int'({cs_n, ras_n, cas_n, we_n}), 4'hf);
      check(addr == '0 && bank == '0, "R1", "addr/bank in reset", int'({bank, addr}), 0);
      check(init_done == 1'b0, "R1", "init_done in reset", int'(init_done), 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   task automatic wait_done(input int limit);
      for (int i = 0; i < limit && !init_done; i++) @(negedge clk);
      check(init_done == 1'b1, "R7", "completion reached", int'(init_done), 1);
   endtask

   task automatic check_after_done();
      repeat (40) @(negedge clk);
      check(init_done == 1'b1, "R9", "done held", int'(init_done), 1);
      check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R8", "NOP after done",
            int'({cs_n, ras_n, cas_n, we_n}), 4'h7);
      check(q.size() == 0, "R4", "expected events left over", q.size(), 0);
      check(r8_bad == 0, "R8", "deselect cycles after clock enable", r8_bad, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "R9", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      // Run 1: complete start-up
      repeat (4) @(negedge clk);
      check_reset_state();
      push_sequence();
      rst_n = 1'b1;
      wait_done(STARTUP + 200);
      check_after_done();

      // Run 2: reset during the refresh phase, then full restart
      @(negedge clk);
      rst_n = 1'b0;
      q.delete();
      repeat (2) @(negedge clk);
      check_reset_state();
      push_sequence();
      rst_n = 1'b1;
      repeat (STARTUP + TRP + 3) @(negedge clk);
      rst_n = 1'b0;
      q.delete();
      repeat (2) @(negedge clk);
      check_reset_state();
      push_sequence();
      rst_n = 1'b1;
      wait_done(STARTUP + 200);
      check_after_done();

      finish_run();
   end

endmodule